// File: doc/BRIEF.md
# Serial Loader Status Register Unit

This block holds the secondary status byte of a byte-oriented serial programming front end. The byte records four results: a control program finished downloading into RAM, the checksum of that download matched, the outcome of the ID verification, and a timeout during data reception. Pulses from the command decoder, the receive path and the checking logic update these flags. The flags are cleared only by a power-on reset or by the clear-status command. An ordinary reset leaves them unchanged.

The unit also answers two commands. The read-status command (0x70) returns two bytes over a valid/ready output: first the primary status byte, supplied on an input, then this unit's own byte. Both values are captured when the command is accepted. The clear-status command (0x50) zeroes the flags. A command marked as needing ID verification is refused with a one-cycle reject pulse unless the ID code shows "verified".

An inter-byte timer watches each multi-byte reception. If no byte arrives within the configured number of cycles, the timer does three things: it raises a discard pulse for the partial data, it ends the reception, and it sets the timeout flag. The front end then returns to the command-wait state.

Top module: `ldr_status_unit`

## Requirements
- R1: After an accepted 0x70 command, `out_valid` rises one cycle later carrying the primary status byte. Once that byte is taken (`out_valid` and `out_ready` both high at a clock edge), the status byte follows. `out_valid` falls after the second byte is taken. While `out_ready` is low, `out_valid` and `out_data` hold.
- R2: While the two reply bytes are pending, `cmd_busy` is high and any arriving command byte is ignored.
- R3: An accepted 0x50 command sets every bit of the status byte to 0 at the next clock edge.
- R4: A low `por_n` forces the status byte to 0x00. A low `rst_n` with `por_n` high leaves the status byte unchanged.
- R5: A `dl_done` pulse sets bit 7.
- R6: A `cks_stb` pulse loads bit 4 with `cks_match`: 1 for a match, 0 for a mismatch.
- R7: Bits 3:2 hold the ID code: 00 not verified, 01 mismatch, 11 verified. An `id_stb` carrying 10 is ignored and the previous code is kept.
- R8: While a reception is active (started by `rx_start`, ended by `rx_done`), the timer restarts on each `rx_byte`. If TIMEOUT_CYC clock edges pass without a byte, `rx_discard` pulses and `rx_active` falls on the same edge, and bit 1 is set on the following edge. A reception that ends by `rx_done` never times out.
- R9: A command with `cmd_needs_id` high while bits 3:2 are not 11 gives a one-cycle `cmd_reject` pulse on the next cycle, and the command has no other effect.
- R10: Bits 6, 5 and 0 always read 0.
- R11: If a clear command and a flag-set event land on the same edge, the set event wins for its field, and all other fields are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears flags |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; flags kept |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Decoded command byte |
| cmd_needs_id | input | 1 | Command requires completed ID verification |
| cmd_busy | output | 1 | Reply in progress, commands ignored |
| cmd_reject | output | 1 | Command refused for lack of ID verification |
| prim_status | input | 8 | Primary status byte to send first |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte accepted by consumer |
| out_data | output | 8 | Reply byte |
| dl_done | input | 1 | Download-to-RAM complete pulse |
| cks_stb | input | 1 | Checksum result pulse |
| cks_match | input | 1 | Checksum result, 1 = match |
| id_stb | input | 1 | ID check result pulse |
| id_code | input | 2 | ID result code |
| rx_start | input | 1 | Multi-byte reception begins |
| rx_byte | input | 1 | One data byte received |
| rx_done | input | 1 | Reception finished normally |
| rx_active | output | 1 | Reception in progress |
| rx_discard | output | 1 | Timeout pulse: drop partial data |
| cmd_wait | output | 1 | Idle in the command-wait state |
| status_byte | output | 8 | Current secondary status byte |

## Verification
The bench tests whether flags survive an ordinary reset. A design that tied the flags to `rst_n` would read 0x00 after that reset instead of the stored value. It also checks that the timer expires exactly TIMEOUT_CYC edges after the last byte. An off-by-one counter would pulse one cycle early or late, and a timer that ignored `rx_byte` would fire in the middle of a reception. The bench further checks the reserved ID code 10, a 0x50 sent during a stalled reply, and a clear that coincides with a download-done pulse. A wrong design would store the reserved code, clear the flags while busy, or drop bit 7.

// File: rtl/ldr_status_pkg.sv
package ldr_status_pkg;

    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;

    localparam logic [1:0] ID_NONE     = 2'b00;
    localparam logic [1:0] ID_MISMATCH = 2'b01;
    localparam logic [1:0] ID_RESERVED = 2'b10;
    localparam logic [1:0] ID_OK       = 2'b11;

    typedef struct packed {
        logic       dl_done;
        logic       rsv6;
        logic       rsv5;
        logic       cks_ok;
        logic [1:0] id_code;
        logic       rx_to;
        logic       rsv0;
    } stat_t;

    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_PRIM = 2'd1,
        RP_SEC  = 2'd2
    } reply_st_t;

endpackage

// File: rtl/ldr_flag_reg.sv
module ldr_flag_reg
    import ldr_status_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       dl_set,
    input  logic       cks_stb,
    input  logic       cks_match,
    input  logic       id_stb,
    input  logic [1:0] id_in,
    input  logic       to_set,
    output stat_t      stat
);

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr) begin
            stat_d = '0;
        end
        if (dl_set) begin
            stat_d.dl_done = 1'b1;
        end
        if (cks_stb) begin
            stat_d.cks_ok = cks_match;
        end
        if (id_stb && (id_in != ID_RESERVED)) begin
            stat_d.id_code = id_in;
        end
        if (to_set) begin
            stat_d.rx_to = 1'b1;
        end
        stat_d.rsv6 = 1'b0;
        stat_d.rsv5 = 1'b0;
        stat_d.rsv0 = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        (stat_q.rsv6 == 1'b0) && (stat_q.rsv5 == 1'b0) && (stat_q.rsv0 == 1'b0));

    assert_id_not_reserved_R7: assert property (@(posedge clk) disable iff (!por_n)
        stat_q.id_code != ID_RESERVED);

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!por_n)
        clr && !dl_set && !cks_stb && !id_stb && !to_set |=> stat_q == '0);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!por_n)
        clr && dl_set |=> stat_q.dl_done);

    assert_timeout_flag_R8: assert property (@(posedge clk) disable iff (!por_n)
        to_set |=> stat_q.rx_to);

endmodule

// File: rtl/ldr_rx_timer.sv
module ldr_rx_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_start,
    input  logic rx_byte,
    input  logic rx_done,
    output logic active,
    output logic expired
);

    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic             active;
        logic             fire;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.fire = 1'b0;
        if (!tmr_q.active) begin
            if (rx_start) begin
                tmr_d.active = 1'b1;
                tmr_d.cnt    = '0;
            end
        end else if (rx_done) begin
            tmr_d.active = 1'b0;
            tmr_d.cnt    = '0;
        end else if (rx_byte || rx_start) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LIMIT) begin
            tmr_d.fire   = 1'b1;
            tmr_d.active = 1'b0;
            tmr_d.cnt    = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active  = tmr_q.active;
    assign expired = tmr_q.fire;

    assert_expiry_ends_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.fire |-> !tmr_q.active);

    assert_done_no_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active && rx_done |=> !tmr_q.fire && !tmr_q.active);

    assert_byte_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active && rx_byte && !rx_done |=> tmr_q.active && !tmr_q.fire);

endmodule

// File: rtl/ldr_reply_seq.sv
module ldr_reply_seq
    import ldr_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_needs_id,
    input  logic       id_verified,
    input  logic [7:0] prim_in,
    input  logic [7:0] sec_in,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       busy,
    output logic       clr_req,
    output logic       reject
);

    typedef struct packed {
        reply_st_t  st;
        logic [7:0] prim;
        logic [7:0] sec;
        logic       rej;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept, denied, exec;

    always_comb begin
        accept  = cmd_valid && (seq_q.st == RP_IDLE);
        denied  = accept && cmd_needs_id && !id_verified;
        exec    = accept && !denied;
        clr_req = exec && (cmd_byte == CMD_CLEAR_STAT);

        seq_d     = seq_q;
        seq_d.rej = denied;
        unique case (seq_q.st)
            RP_IDLE: begin
                if (exec && (cmd_byte == CMD_READ_STAT)) begin
                    seq_d.st   = RP_PRIM;
                    seq_d.prim = prim_in;
                    seq_d.sec  = sec_in;
                end
            end
            RP_PRIM: begin
                if (out_ready) seq_d.st = RP_SEC;
            end
            RP_SEC: begin
                if (out_ready) seq_d.st = RP_IDLE;
            end
            default: seq_d.st = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign out_valid = (seq_q.st != RP_IDLE);
    assign out_data  = (seq_q.st == RP_SEC) ? seq_q.sec : seq_q.prim;
    assign busy      = out_valid;
    assign reject    = seq_q.rej;

    assert_hold_while_stalled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_prim_then_sec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == RP_PRIM) && out_ready |=> (seq_q.st == RP_SEC));

    assert_busy_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid |=> !reject);

    assert_reject_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        denied |=> reject && (seq_q.st == RP_IDLE));

endmodule

// File: rtl/ldr_status_unit.sv
module ldr_status_unit
    import ldr_status_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_needs_id,
    output logic       cmd_busy,
    output logic       cmd_reject,
    input  logic [7:0] prim_status,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    input  logic       dl_done,
    input  logic       cks_stb,
    input  logic       cks_match,
    input  logic       id_stb,
    input  logic [1:0] id_code,
    input  logic       rx_start,
    input  logic       rx_byte,
    input  logic       rx_done,
    output logic       rx_active,
    output logic       rx_discard,
    output logic       cmd_wait,
    output logic [7:0] status_byte
);

    logic  sys_rst_n;
    logic  clr_req;
    stat_t stat;

    assign sys_rst_n = rst_n & por_n;

    ldr_flag_reg u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (clr_req),
        .dl_set    (dl_done),
        .cks_stb   (cks_stb),
        .cks_match (cks_match),
        .id_stb    (id_stb),
        .id_in     (id_code),
        .to_set    (rx_discard),
        .stat      (stat)
    );

    ldr_rx_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .rx_start (rx_start),
        .rx_byte  (rx_byte),
        .rx_done  (rx_done),
        .active   (rx_active),
        .expired  (rx_discard)
    );

    ldr_reply_seq u_reply (
        .clk          (clk),
        .rst_n        (sys_rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_byte     (cmd_byte),
        .cmd_needs_id (cmd_needs_id),
        .id_verified  (stat.id_code == ID_OK),
        .prim_in      (prim_status),
        .sec_in       (stat),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .busy         (cmd_busy),
        .clr_req      (clr_req),
        .reject       (cmd_reject)
    );

    assign status_byte = stat;
    assign cmd_wait    = !cmd_busy && !rx_active;

endmodule

// File: tb/ldr_status_unit_test.sv
module ldr_status_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 8;

    logic       clk = 1'b0;
    logic       por_n, rst_n;
    logic       cmd_valid, cmd_needs_id, out_ready;
    logic [7:0] cmd_byte, prim_status;
    logic       dl_done, cks_stb, cks_match, id_stb;
    logic [1:0] id_code;
    logic       rx_start, rx_byte, rx_done;
    logic       cmd_busy, cmd_reject, out_valid, rx_active, rx_discard, cmd_wait;
    logic [7:0] out_data, status_byte;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldr_status_unit #(.TIMEOUT_CYC(TO_CYC)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_needs_id(cmd_needs_id),
        .cmd_busy(cmd_busy), .cmd_reject(cmd_reject), .prim_status(prim_status),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .dl_done(dl_done), .cks_stb(cks_stb), .cks_match(cks_match),
        .id_stb(id_stb), .id_code(id_code),
        .rx_start(rx_start), .rx_byte(rx_byte), .rx_done(rx_done),
        .rx_active(rx_active), .rx_discard(rx_discard), .cmd_wait(cmd_wait),
        .status_byte(status_byte)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] b, input logic need);
        cmd_valid = 1'b1; cmd_byte = b; cmd_needs_id = need;
        tick();
        cmd_valid = 1'b0; cmd_needs_id = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R4 por value", status_byte, 8'h00);
        check("R1 idle out_valid", {7'd0, out_valid}, 8'h00);
        check("R2 idle busy", {7'd0, cmd_busy}, 8'h00);
        check("R8 idle cmd_wait", {7'd0, cmd_wait}, 8'h01);
    endtask

    task automatic t_download();
        dl_done = 1'b1; tick(); dl_done = 1'b0;
        check("R5 download bit", status_byte, 8'h80);
        check("R10 reserved bits", status_byte & 8'h61, 8'h00);
    endtask

    task automatic t_checksum();
        cks_stb = 1'b1; cks_match = 1'b1; tick(); cks_stb = 1'b0;
        check("R6 checksum match", status_byte, 8'h90);
        cks_stb = 1'b1; cks_match = 1'b0; tick(); cks_stb = 1'b0;
        check("R6 checksum mismatch", status_byte, 8'h80);
    endtask

    task automatic t_id_code();
        id_stb = 1'b1; id_code = 2'b01; tick(); id_stb = 1'b0;
        check("R7 id mismatch code", status_byte, 8'h84);
        id_stb = 1'b1; id_code = 2'b10; tick(); id_stb = 1'b0;
        check("R7 reserved id ignored", status_byte, 8'h84);
        id_stb = 1'b1; id_code = 2'b11; tick(); id_stb = 1'b0;
        check("R7 id verified code", status_byte, 8'h8C);
    endtask

    task automatic t_read_status();
        prim_status = 8'hA5;
        out_ready   = 1'b0;
        send_cmd(8'h70, 1'b0);
        check("R1 first byte valid", {7'd0, out_valid}, 8'h01);
        check("R1 first byte primary", out_data, 8'hA5);
        check("R2 busy during reply", {7'd0, cmd_busy}, 8'h01);
        send_cmd(8'h50, 1'b0);
        check("R1 stalled byte held", out_data, 8'hA5);
        out_ready = 1'b1;
        tick();
        check("R1 second byte status", out_data, 8'h8C);
        check("R1 second byte valid", {7'd0, out_valid}, 8'h01);
        tick();
        out_ready = 1'b0;
        check("R1 reply ends", {7'd0, out_valid}, 8'h00);
        check("R2 clear ignored while busy", status_byte, 8'h8C);
    endtask

    task automatic t_rst_keeps();
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        check("R4 ordinary reset keeps flags", status_byte, 8'h8C);
    endtask

    task automatic t_timeout();
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        check("R8 reception active", {7'd0, rx_active}, 8'h01);
        repeat (TO_CYC - 1) tick();
        check("R8 no early expiry", {6'd0, rx_active, rx_discard}, 8'h02);
        tick();
        check("R8 expiry discard", {6'd0, rx_active, rx_discard}, 8'h01);
        tick();
        check("R8 timeout flag", status_byte, 8'h8E);
        check("R8 back to command wait", {7'd0, cmd_wait}, 8'h01);
    endtask

    task automatic t_restart();
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        repeat (5) tick();
        rx_byte = 1'b1; tick(); rx_byte = 1'b0;
        repeat (TO_CYC - 1) tick();
        check("R8 byte restarts timer", {6'd0, rx_active, rx_discard}, 8'h02);
        tick();
        check("R8 expiry after restart", {6'd0, rx_active, rx_discard}, 8'h01);
    endtask

    task automatic t_done_stops();
        int seen = 0;
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        repeat (3) tick();
        rx_done = 1'b1; tick(); rx_done = 1'b0;
        check("R8 done ends reception", {7'd0, rx_active}, 8'h00);
        for (int i = 0; i < 2 * TO_CYC; i++) begin
            tick();
            if (rx_discard) seen++;
        end
        check("R8 no expiry after done", 8'(seen), 8'h00);
    endtask

    task automatic t_clear();
        send_cmd(8'h50, 1'b0);
        check("R3 clear zeroes flags", status_byte, 8'h00);
    endtask

    task automatic t_reject();
        dl_done = 1'b1; tick(); dl_done = 1'b0;
        send_cmd(8'h50, 1'b1);
        check("R9 reject pulse", {7'd0, cmd_reject}, 8'h01);
        check("R9 clear not executed", status_byte, 8'h80);
        tick();
        check("R9 reject one cycle", {7'd0, cmd_reject}, 8'h00);
        send_cmd(8'h70, 1'b1);
        check("R9 read not executed", {6'd0, out_valid, cmd_reject}, 8'h01);
        tick();
    endtask

    task automatic t_priority();
        cks_stb = 1'b1; cks_match = 1'b1; tick(); cks_stb = 1'b0;
        check("R6 checksum before priority", status_byte, 8'h90);
        cmd_valid = 1'b1; cmd_byte = 8'h50; dl_done = 1'b1;
        tick();
        cmd_valid = 1'b0; dl_done = 1'b0;
        check("R11 set beats clear", status_byte, 8'h80);
    endtask

    task automatic t_por();
        id_stb = 1'b1; id_code = 2'b11; tick(); id_stb = 1'b0;
        por_n = 1'b0; tick(); por_n = 1'b1; tick();
        check("R4 power-on clears", status_byte, 8'h00);
    endtask

    initial begin
        por_n = 1'b0; rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_byte = 8'h00; cmd_needs_id = 1'b0; out_ready = 1'b0;
        prim_status = 8'h00; dl_done = 1'b0; cks_stb = 1'b0; cks_match = 1'b0;
        id_stb = 1'b0; id_code = 2'b00; rx_start = 1'b0; rx_byte = 1'b0; rx_done = 1'b0;
        repeat (3) tick();
        por_n = 1'b1; rst_n = 1'b1;
        tick();
        t_reset_state();
        t_download();
        t_checksum();
        t_id_code();
        t_read_status();
        t_rst_keeps();
        t_timeout();
        t_restart();
        t_done_stops();
        t_clear();
        t_reject();
        t_priority();
        t_por();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule